// File: doc/BRIEF.md
# March Memory Self-Test Controller

This block is a built-in self-test engine for a synchronous single-port SRAM. Software or a test controller gives it a start byte address, a length in bytes and an error-handling mode, then pulses a start strobe. The engine takes over the SRAM port. It runs eight fixed phases of a March-style pattern over the selected words. In each element it reads a word, compares it with an all-zeros or all-ones pattern and writes the complement back. Some phases walk the address range upward and others walk it downward.

When a word does not match, the engine captures the faulting byte address, the word it read and the lowest mismatching bit. It then stops in one of two ways. In exit mode it ends the run. In pause mode it freezes until the fail flag is cleared, and then continues where it stopped. A protection input blocks the test from starting. A cancel strobe stops a run at any time.

Top module: `mtest_engine`

## Requirements
- R1: Phase 0 walks the range upward and writes zero to every word. It never reports a mismatch, so any previous contents of the SRAM are harmless and a clean memory ends with only DONE set. The range covers `length_i >> log2(DATA_W/8)` words, starting at word `base_addr_i >> log2(DATA_W/8)`.
- R2: Phases 1–6 each read a word, compare it with an expected value and write the complement. The expected values are 0,1,0,1,0,1. Phases 3, 4 and 6 walk downward and the other phases walk upward. Every written word is all zeros or all ones.
- R3: Phase 7 walks upward and checks that each word reads all zeros. It writes nothing, and a mismatch in this phase reports bit index 0.
- R4: Phase 0 takes one cycle per word and every later element takes two cycles. A clean run over N words therefore raises DONE exactly 15·N clock edges after the edge that accepts the start.
- R5: Mode value 0 selects exit-on-error. The first mismatch ends the run with DONE and FAIL both set. A clean run sets DONE alone. An accepted start clears DONE and FAIL.
- R6: Mode value 1 selects pause-on-error. A mismatch sets FAIL only and the SRAM port goes idle. Pulsing `fail_clr_i` clears FAIL, writes the complement to the faulting word (except in phase 7) and continues with the next element.
- R7: On a mismatch the engine latches three values: the byte address of the failing word, the raw word that was read, and the lowest bit position that differs from the expected pattern.
- R8: `cancel_i` returns the engine to idle on the next edge, whatever state it is in. After that the SRAM port stays idle and DONE stays low until a new start is accepted.
- R9: A start while `prot_i` is high does not run the test. It sets the protection-error flag and leaves the SRAM idle. The next accepted start clears that flag.
- R10: Three kinds of start are ignored: a start while a run is in progress, a start whose length is shorter than one word, and a start with mode value 2 or 3. None of them affects the SRAM port or the status flags.
- R11: After reset, DONE, FAIL and the protection-error flag are low and the SRAM port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, one cycle |
| cancel_i | input | 1 | Abort strobe, one cycle |
| mode_i | input | 2 | 0 exit-on-error, 1 pause-on-error, 2–3 illegal |
| prot_i | input | 1 | Device protected; blocks starting |
| base_addr_i | input | ADDR_W | Start byte address |
| length_i | input | ADDR_W+1 | Range length in bytes |
| fail_clr_i | input | 1 | Clears FAIL; resumes a paused run |
| sram_en_o | output | 1 | SRAM access enable |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | ADDR_W-log2(DATA_W/8) | SRAM word address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| sram_rdata_i | input | DATA_W | SRAM read data, one cycle after the read |
| done_o | output | 1 | Run finished |
| fail_o | output | 1 | Mismatch detected |
| perr_o | output | 1 | Start refused because of protection |
| fail_addr_o | output | ADDR_W | Byte address of the failing word |
| fail_data_o | output | DATA_W | Word read at the failure |
| fail_bit_o | output | log2(DATA_W) | Lowest mismatching bit position |

## Verification
The bench builds the engine with ADDR_W=8 and DATA_W=16, which gives 128 words of two bytes each. With two-byte words, the byte-to-word conversion is exercised. This covers dropping an odd trailing byte, and lengths of a single byte that round down to zero words. Stuck-at cells of either polarity are placed inside and outside the range. This is enough to reach every phase that can detect a fault, including the two downward phases after resume and the all-zero final read. Because the memory is small, full runs stay short enough to count every clock edge of the run.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR0,
    ST_RD,
    ST_CMP,
    ST_PAUSE,
    ST_RESUME
  } mt_state_e;

  localparam logic [1:0] MODE_EXIT  = 2'd0;
  localparam logic [1:0] MODE_PAUSE = 2'd1;
  localparam logic [2:0] LAST_PHASE = 3'd7;

  // Address direction of a phase: 1 = ascending
  function automatic logic ph_up(input logic [2:0] p);
    return !(p == 3'd3 || p == 3'd4 || p == 3'd6);
  endfunction

  // Value the read of a phase expects in every bit
  function automatic logic ph_exp_one(input logic [2:0] p);
    return (p == 3'd2 || p == 3'd4 || p == 3'd6);
  endfunction

endpackage

// File: rtl/mt_addr_seq.sv
module mt_addr_seq #(
  parameter int WA = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          up_i,
  input  logic          step_i,
  input  logic [WA:0]   words_i,
  output logic [WA-1:0] ofs_o,
  output logic          last_o
);
  logic          up_q;
  logic [WA:0]   wm1;

  assign wm1 = words_i - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_o <= '0;
      up_q  <= 1'b1;
    end else if (load_i) begin
      up_q  <= up_i;
      ofs_o <= up_i ? '0 : wm1[WA-1:0];
    end else if (step_i) begin
      ofs_o <= up_q ? ofs_o + 1'b1 : ofs_o - 1'b1;
    end
  end

  assign last_o = up_q ? ({1'b0, ofs_o} == wm1) : (ofs_o == '0);

endmodule

// File: rtl/mt_word_cmp.sv
module mt_word_cmp #(
  parameter int DW = 8,
  parameter int BW = 3
) (
  input  logic [DW-1:0] rdata_i,
  input  logic          exp_one_i,
  output logic          mis_o,
  output logic [BW-1:0] bit_o
);
  logic [DW-1:0] diff;

  assign diff  = rdata_i ^ {DW{exp_one_i}};
  assign mis_o = |diff;

  // Lowest differing bit wins: scan from the top down
  always_comb begin
    bit_o = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      if (diff[i]) bit_o = BW'(i);
    end
  end

endmodule

// File: rtl/mtest_engine.sv
module mtest_engine
  import mt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int BSH = $clog2(DATA_W / 8),
  localparam int WA  = ADDR_W - BSH,
  localparam int BW  = (DATA_W > 1) ? $clog2(DATA_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic [1:0]        mode_i,
  input  logic              prot_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W:0]   length_i,
  input  logic              fail_clr_i,
  output logic              sram_en_o,
  output logic              sram_we_o,
  output logic [WA-1:0]     sram_addr_o,
  output logic [DATA_W-1:0] sram_wdata_o,
  input  logic [DATA_W-1:0] sram_rdata_i,
  output logic              done_o,
  output logic              fail_o,
  output logic              perr_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_data_o,
  output logic [BW-1:0]     fail_bit_o
);

  mt_state_e    st;
  logic [2:0]   phase;
  logic [WA-1:0] base_q;
  logic [WA:0]  words_q;
  logic         mode_q;

  logic [WA:0]  words_in, words_cur;
  logic [WA-1:0] ofs;
  logic         last, mis;
  logic [BW-1:0] mis_bit;
  logic         accept, adv, seq_load, seq_dir, seq_step, exp_one;
  logic [2:0]   phase_nx;

  assign words_in  = length_i[ADDR_W:BSH];
  assign words_cur = (st == ST_IDLE) ? words_in : words_q;
  assign phase_nx  = phase + 3'd1;
  assign exp_one   = ph_exp_one(phase);

  assign accept = (st == ST_IDLE) && start_i && !cancel_i && !prot_i &&
                  (words_in != '0) &&
                  (mode_i == MODE_EXIT || mode_i == MODE_PAUSE);

  assign adv = !cancel_i && ((st == ST_WR0) || (st == ST_RESUME) ||
                             (st == ST_CMP && !mis));

  assign seq_load = accept || (adv && last && phase != LAST_PHASE);
  assign seq_dir  = accept ? 1'b1 : ph_up(phase_nx);
  assign seq_step = adv && !last;

  mt_addr_seq #(.WA(WA)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .load_i  (seq_load),
    .up_i    (seq_dir),
    .step_i  (seq_step),
    .words_i (words_cur),
    .ofs_o   (ofs),
    .last_o  (last)
  );

  mt_word_cmp #(.DW(DATA_W), .BW(BW)) u_cmp (
    .rdata_i   (sram_rdata_i),
    .exp_one_i (exp_one),
    .mis_o     (mis),
    .bit_o     (mis_bit)
  );

  assign sram_addr_o = base_q + ofs;

  // SRAM port: write the complement of the expected pattern
  always_comb begin
    sram_en_o    = 1'b0;
    sram_we_o    = 1'b0;
    sram_wdata_o = (phase == 3'd0 || exp_one) ? '0 : '1;
    unique case (st)
      ST_WR0:    begin sram_en_o = 1'b1; sram_we_o = 1'b1; end
      ST_RD:     sram_en_o = 1'b1;
      ST_CMP:    begin
                   sram_en_o = !mis && (phase != LAST_PHASE);
                   sram_we_o = sram_en_o;
                 end
      ST_RESUME: begin
                   sram_en_o = (phase != LAST_PHASE);
                   sram_we_o = sram_en_o;
                 end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      phase       <= '0;
      base_q      <= '0;
      words_q     <= '0;
      mode_q      <= 1'b0;
      done_o      <= 1'b0;
      fail_o      <= 1'b0;
      perr_o      <= 1'b0;
      fail_addr_o <= '0;
      fail_data_o <= '0;
      fail_bit_o  <= '0;
    end else begin
      if (fail_clr_i) fail_o <= 1'b0;
      if (cancel_i) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_IDLE: begin
            if (start_i && prot_i) perr_o <= 1'b1;
            if (accept) begin
              perr_o  <= 1'b0;
              done_o  <= 1'b0;
              fail_o  <= 1'b0;
              base_q  <= base_addr_i[ADDR_W-1:BSH];
              words_q <= words_in;
              mode_q  <= mode_i[0];
              phase   <= '0;
              st      <= ST_WR0;
            end
          end
          ST_RD:    st <= ST_CMP;
          ST_CMP: begin
            if (mis) begin
              fail_o      <= 1'b1;
              fail_addr_o <= ADDR_W'(sram_addr_o) << BSH;
              fail_data_o <= sram_rdata_i;
              fail_bit_o  <= (phase == LAST_PHASE) ? '0 : mis_bit;
              if (mode_q) begin
                st <= ST_PAUSE;
              end else begin
                done_o <= 1'b1;
                st     <= ST_IDLE;
              end
            end
          end
          ST_PAUSE: if (fail_clr_i) st <= ST_RESUME;
          default: ;
        endcase
        if (adv) begin
          if (!last) begin
            st <= (st == ST_WR0) ? ST_WR0 : ST_RD;
          end else if (phase == LAST_PHASE) begin
            done_o <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            phase <= phase_nx;
            st    <= ST_RD;
          end
        end
      end
    end
  end

endmodule

// File: rtl/mtest_engine_chk.sv
module mtest_engine_chk #(
  parameter int DATA_W = 8,
  parameter int WA     = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cancel_i,
  input logic              done_o,
  input logic              fail_o,
  input logic              perr_o,
  input logic              sram_en_o,
  input logic              sram_we_o,
  input logic [WA-1:0]     sram_addr_o,
  input logic [DATA_W-1:0] sram_wdata_o,
  input logic [WA-1:0]     base_q,
  input logic [WA:0]       words_q
);
  logic [WA-1:0] rel;
  assign rel = sram_addr_o - base_q;

  p_addr_window_r1: assert property (@(posedge clk) disable iff (rst)
    sram_en_o |-> ({1'b0, rel} < words_q));

  p_wdata_solid_r2: assert property (@(posedge clk) disable iff (rst)
    (sram_en_o && sram_we_o) |->
      ($countones(sram_wdata_o) == 0 || $countones(sram_wdata_o) == DATA_W));

  p_frozen_pause_r6: assert property (@(posedge clk) disable iff (rst)
    (fail_o && !done_o) |-> !sram_en_o);

  p_cancel_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    cancel_i |=> !sram_en_o);

  p_perr_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    perr_o |-> !sram_en_o);

  p_we_needs_en_r2: assert property (@(posedge clk) disable iff (rst)
    sram_we_o |-> sram_en_o);

endmodule

bind mtest_engine mtest_engine_chk #(.DATA_W(DATA_W), .WA(WA)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cancel_i     (cancel_i),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .perr_o       (perr_o),
  .sram_en_o    (sram_en_o),
  .sram_we_o    (sram_we_o),
  .sram_addr_o  (sram_addr_o),
  .sram_wdata_o (sram_wdata_o),
  .base_q       (base_q),
  .words_q      (words_q)
);

// File: tb/mtest_engine_bench.sv
`timescale 1ns/1ps
module mtest_engine_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int WA = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, cancel_i = 0, prot_i = 0, fail_clr_i = 0;
  logic [1:0] mode_i = 0;
  logic [AW-1:0] base_addr_i = 0;
  logic [AW:0] length_i = 0;
  logic sram_en_o, sram_we_o;
  logic [WA-1:0] sram_addr_o;
  logic [DW-1:0] sram_wdata_o, sram_rdata_i;
  logic done_o, fail_o, perr_o;
  logic [AW-1:0] fail_addr_o;
  logic [DW-1:0] fail_data_o;
  logic [3:0] fail_bit_o;

  always #4 clk = ~clk;

  mtest_engine #(.ADDR_W(AW), .DATA_W(DW)) u_mtest_engine (.*);

  // SRAM model with up to two stuck-at cells
  logic [DW-1:0] mem [0:(1<<WA)-1];
  logic fe0 = 0, fe1 = 0, fv0 = 0, fv1 = 0;
  logic [WA-1:0] fw0 = 0, fw1 = 0;
  logic [3:0] fb0 = 0, fb1 = 0;
  int cyc = 0, en_cnt = 0, n_chk = 0, n_fail = 0;

  function automatic logic [DW-1:0] faulty(input logic [WA-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r = d;
    if (fe0 && a == fw0) r[fb0] = fv0;
    if (fe1 && a == fw1) r[fb1] = fv1;
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sram_en_o) begin
      en_cnt <= en_cnt + 1;
      if (sram_we_o) mem[sram_addr_o] <= faulty(sram_addr_o, sram_wdata_o);
      else sram_rdata_i <= mem[sram_addr_o];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int t0;
  task automatic start_run(input logic [1:0] m, input logic [AW-1:0] b, input logic [AW:0] l);
    @(negedge clk);
    mode_i = m; base_addr_i = b; length_i = l; start_i = 1;
    @(negedge clk);
    start_i = 0;
    t0 = cyc;
  endtask

  task automatic wait_ev();
    int g = 0;
    while (!(fail_o || done_o) && g < 20000) begin
      @(negedge clk); g++;
    end
  endtask

  typedef struct packed {
    logic [7:0]  base;
    logic [8:0]  len;
    logic        fen;
    logic [6:0]  fw;
    logic [3:0]  fb;
    logic        fv;
    logic        efail;
    logic [7:0]  eaddr;
    logic [15:0] edata;
    logic [3:0]  ebit;
    logic [9:0]  ecyc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{base:8'h00, len:9'd16, fen:1'b0, fw:7'h00, fb:4'd0,  fv:1'b0, efail:1'b0, eaddr:8'h00, edata:16'h0000, ebit:4'd0,  ecyc:10'd120},
    '{base:8'h20, len:9'd32, fen:1'b1, fw:7'h14, fb:4'd5,  fv:1'b1, efail:1'b1, eaddr:8'h28, edata:16'h0020, ebit:4'd5,  ecyc:10'd26},
    '{base:8'h40, len:9'd20, fen:1'b1, fw:7'h25, fb:4'd0,  fv:1'b0, efail:1'b1, eaddr:8'h4A, edata:16'hFFFE, ebit:4'd0,  ecyc:10'd42},
    '{base:8'h10, len:9'd8,  fen:1'b1, fw:7'h30, fb:4'd2,  fv:1'b1, efail:1'b0, eaddr:8'h00, edata:16'h0000, ebit:4'd0,  ecyc:10'd60},
    '{base:8'h60, len:9'd7,  fen:1'b1, fw:7'h33, fb:4'd15, fv:1'b1, efail:1'b0, eaddr:8'h00, edata:16'h0000, ebit:4'd0,  ecyc:10'd45},
    '{base:8'h60, len:9'd7,  fen:1'b1, fw:7'h32, fb:4'd15, fv:1'b1, efail:1'b1, eaddr:8'h64, edata:16'h8000, ebit:4'd15, ecyc:10'd9}
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 actual=timeout expected=finish");
    summary();
  end

  initial begin
    int e0;
    for (int i = 0; i < (1 << WA); i++) mem[i] = 16'hA5C3 ^ 16'(i * 37);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 done", done_o, 0);
    chk("R11 fail", fail_o, 0);
    chk("R11 perr", perr_o, 0);
    chk("R11 sram idle", sram_en_o, 0);

    // Exit-on-error vector table
    foreach (VEC[k]) begin
      fe0 = VEC[k].fen; fw0 = VEC[k].fw; fb0 = VEC[k].fb; fv0 = VEC[k].fv; fe1 = 0;
      start_run(2'd0, VEC[k].base, VEC[k].len);
      wait_ev();
      chk($sformatf("R4 cycles vec%0d", k), cyc - t0, VEC[k].ecyc);
      chk($sformatf("R5 done vec%0d", k), done_o, 1);
      chk($sformatf("R1 R5 fail vec%0d", k), fail_o, VEC[k].efail);
      if (VEC[k].efail) begin
        chk($sformatf("R7 addr vec%0d", k), fail_addr_o, VEC[k].eaddr);
        chk($sformatf("R7 data vec%0d", k), fail_data_o, VEC[k].edata);
        chk($sformatf("R7 bit vec%0d", k), fail_bit_o, VEC[k].ebit);
      end
    end
    fe0 = 0;

    // R10 zero length (one byte rounds to zero words) and reserved modes
    e0 = en_cnt;
    start_run(2'd0, 8'h00, 9'd1);
    start_run(2'd2, 8'h00, 9'd16);
    start_run(2'd3, 8'h00, 9'd16);
    repeat (20) @(negedge clk);
    chk("R10 ignored starts no access", en_cnt - e0, 0);
    chk("R10 done kept", done_o, 1);

    // R9 protection
    prot_i = 1;
    e0 = en_cnt;
    start_run(2'd0, 8'h00, 9'd16);
    repeat (10) @(negedge clk);
    chk("R9 perr set", perr_o, 1);
    chk("R9 no access", en_cnt - e0, 0);
    prot_i = 0;
    start_run(2'd0, 8'h00, 9'd16);
    chk("R9 perr cleared", perr_o, 0);
    wait_ev();
    chk("R9 run after unprotect", done_o, 1);

    // R10 start while busy is ignored
    fe0 = 1; fw0 = 7'h20; fb0 = 4'd1; fv0 = 1;
    start_run(2'd0, 8'h00, 9'd16);
    repeat (10) @(negedge clk);
    start_i = 1; base_addr_i = 8'h40; length_i = 9'd2;
    @(negedge clk); start_i = 0;
    wait_ev();
    chk("R10 busy start cycles", cyc - t0, 120);
    chk("R10 busy start fail", fail_o, 0);
    fe0 = 0;

    // R8 cancel
    start_run(2'd0, 8'h00, 9'd32);
    repeat (10) @(negedge clk);
    cancel_i = 1; @(negedge clk); cancel_i = 0;
    e0 = en_cnt;
    repeat (20) @(negedge clk);
    chk("R8 quiet after cancel", en_cnt - e0, 0);
    chk("R8 no done", done_o, 0);
    start_run(2'd0, 8'h00, 9'd32);
    wait_ev();
    chk("R8 rerun cycles", cyc - t0, 240);

    // R2 R6 pause mode, two stuck-at-0 cells: order shows direction per phase
    fe0 = 1; fw0 = 7'd3; fb0 = 4'd2; fv0 = 0;
    fe1 = 1; fw1 = 7'd9; fb1 = 4'd7; fv1 = 0;
    start_run(2'd1, 8'h00, 9'd32);
    begin
      logic [6:0] wseq [6] = '{7'd3, 7'd9, 7'd9, 7'd3, 7'd9, 7'd3};
      for (int j = 0; j < 6; j++) begin
        wait_ev();
        chk($sformatf("R6 pause%0d fail", j), fail_o, 1);
        chk($sformatf("R6 pause%0d no done", j), done_o, 0);
        chk($sformatf("R2 pause%0d addr", j), fail_addr_o, {wseq[j], 1'b0});
        chk($sformatf("R7 pause%0d bit", j), fail_bit_o, (wseq[j] == 7'd3) ? 2 : 7);
        chk($sformatf("R7 pause%0d data", j), fail_data_o,
            (wseq[j] == 7'd3) ? 16'hFFFB : 16'hFF7F);
        e0 = en_cnt;
        repeat (4) @(negedge clk);
        chk($sformatf("R6 pause%0d frozen", j), en_cnt - e0, 0);
        fail_clr_i = 1; @(negedge clk); fail_clr_i = 0;
        chk($sformatf("R6 pause%0d cleared", j), fail_o, 0);
      end
    end
    wait_ev();
    chk("R6 final done", done_o, 1);
    chk("R6 final fail", fail_o, 0);

    // R3 stuck-at-1: pauses in phases 1,3,5,7; last one reports bit 0
    fe1 = 0; fe0 = 1; fw0 = 7'd5; fb0 = 4'd3; fv0 = 1;
    start_run(2'd1, 8'h00, 9'd32);
    for (int j = 0; j < 4; j++) begin
      wait_ev();
      chk($sformatf("R6 s1 pause%0d", j), fail_o & ~done_o, 1);
      chk($sformatf("R7 s1 addr%0d", j), fail_addr_o, 8'h0A);
      chk($sformatf("R7 s1 data%0d", j), fail_data_o, 16'h0008);
      chk($sformatf("R3 s1 bit%0d", j), fail_bit_o, (j == 3) ? 0 : 3);
      fail_clr_i = 1; @(negedge clk); fail_clr_i = 0;
    end
    wait_ev();
    chk("R3 done after phase 7", done_o, 1);
    summary();
  end

endmodule